// File: doc/BRIEF.md
# Issue-Stage Interlock Scoreboard with Load Delay Slot

This block sits in the issue stage of a single-issue, in-order pipeline and decides, each cycle, whether the instruction presented for issue may leave. It combines two ways of handling hazards. The first is an architectural load delay slot, which hardware never checks. The second is a hardware scoreboard, which stalls a dependent instruction only for the part of a producer's real latency that software was not told to cover. Loads, integer multiply, integer divide and two floating-point groups each have their own latency parameter. A binary scheduled for one delay slot therefore keeps running correctly on an implementation whose memory or arithmetic is slower.

Each architectural register has its own down-counter. When an instruction issues with a destination, the counter for that destination is loaded with the producer's latency minus one. After that it counts down by one on every clock, stalled or not, and the register is ready once its counter reaches zero. While the instruction at issue is stalled it is held where it is, and no counter is loaded. Register 0 always reads as zero and is never tracked.

Top module: `iss_interlock`

## Requirements
- R1: A synchronous active-high `rst` makes every register ready and keeps `stall` low for an idle issue port.
- R2: The instruction issued in the cycle right after a load (class code 1) is never stalled by that load's destination, whether it reads that register or writes it.
- R3: Take a load issued in cycle t with latency `LAT_LOAD` and `LOAD_SLOTS` delay slots. An instruction that depends on it and is presented in cycle t+k is stalled when LOAD_SLOTS < k < LAT_LOAD, and it may issue from cycle t+LAT_LOAD on.
- R4: A consumer of an integer multiply (class code 2) stalls until `LAT_MUL` cycles after the multiply issued.
- R5: A consumer of an integer divide (class code 3) stalls until `LAT_DIV` cycles after the divide issued.
- R6: Floating-point operations (class code 4 short, `LAT_FSHORT`; class code 5 long, `LAT_FLONG`) that are independent of each other issue in back-to-back cycles, and each consumer waits for its own producer's latency.
- R7: An instruction whose destination still has a pending write is stalled, so that writes to one register cannot complete out of order.
- R8: Register 0 never becomes pending. Reading it or writing it never causes a stall.
- R9: While `stall` is high, the held instruction loads no counter, so its destination stays ready.
- R10: A source whose use flag is low has no effect on `stall`.
- R11: `stall` is high only while `iss_valid` is high. An invalid slot loads no counter.
- R12: Class codes 0, 6 and 7 have a latency of `LAT_ALU`. `reg_ready[i]` is 1 exactly when register i's counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_class | input | 3 | Operation class: 0 simple, 1 load, 2 multiply, 3 divide, 4 short FP, 5 long FP |
| src_a | input | IW | First source register number |
| src_a_use | input | 1 | First source is read |
| src_b | input | IW | Second source register number |
| src_b_use | input | 1 | Second source is read |
| dst | input | IW | Destination register number |
| dst_we | input | 1 | Instruction writes `dst` |
| stall | output | 1 | Hold the presented instruction this cycle |
| reg_ready | output | NREGS | Per-register result-written flag |

## Verification
The bench tests the cycle just after a load and the one after that. A design that skips the slot exemption stalls the first of these and fails R2. A design that over-credits the slot lets the second through and fails R3. Every producer is then followed by a consumer presented on each cycle until its result is ready. An off-by-one in a load value or in a decrement shows up as a stall that ends one cycle early or one cycle late. Further cases cover a write to a register that is still pending, a write to register 0, a held instruction whose own destination must stay ready, unused sources and invalid slots. Any design that loads a counter while stalled, or that lets an invalid or masked field count as a hazard, shows up as a flipped `stall` or a wrong `reg_ready` bit. A long pseudo-random mix of instructions then compares both outputs against the behavioural model on every cycle.

// File: rtl/iil_pkg.sv
package iil_pkg;
   typedef enum logic [2:0] {
      OP_ALU    = 3'd0,
      OP_LOAD   = 3'd1,
      OP_MUL    = 3'd2,
      OP_DIV    = 3'd3,
      OP_FSHORT = 3'd4,
      OP_FLONG  = 3'd5
   } op_class_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int max_lat(input int l0, input int l1, input int l2,
                                  input int l3, input int l4, input int l5);
      return max2(max2(max2(l0, l1), max2(l2, l3)), max2(l4, l5));
   endfunction
endpackage

// File: rtl/iil_latency.sv
module iil_latency
   import iil_pkg::*;
#(
   parameter int LAT_ALU    = 1,
   parameter int LAT_LOAD   = 2,
   parameter int LAT_MUL    = 6,
   parameter int LAT_DIV    = 16,
   parameter int LAT_FSHORT = 2,
   parameter int LAT_FLONG  = 3,
   parameter int CW         = 5
) (
   input  logic [2:0]    cls,
   output logic [CW-1:0] load_val,
   output logic          is_load
);
   localparam logic [CW-1:0] V_ALU    = CW'(LAT_ALU - 1);
   localparam logic [CW-1:0] V_LOAD   = CW'(LAT_LOAD - 1);
   localparam logic [CW-1:0] V_MUL    = CW'(LAT_MUL - 1);
   localparam logic [CW-1:0] V_DIV    = CW'(LAT_DIV - 1);
   localparam logic [CW-1:0] V_FSHORT = CW'(LAT_FSHORT - 1);
   localparam logic [CW-1:0] V_FLONG  = CW'(LAT_FLONG - 1);

   always_comb begin
      is_load = 1'b0;
      case (op_class_e'(cls))
         OP_LOAD: begin
            load_val = V_LOAD;
            is_load  = 1'b1;
         end
         OP_MUL:    load_val = V_MUL;
         OP_DIV:    load_val = V_DIV;
         OP_FSHORT: load_val = V_FSHORT;
         OP_FLONG:  load_val = V_FLONG;
         default:   load_val = V_ALU;
      endcase
   end
endmodule

// File: rtl/iil_reg_slot.sv
module iil_reg_slot #(
   parameter int CW         = 5,
   parameter int LOAD_SLOTS = 1,
   parameter int SLOT_THR   = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_en,
   input  logic [CW-1:0] load_val,
   input  logic          load_is_ld,
   output logic          busy,
   output logic          ready
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load_en)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign ready = (cnt == '0);

   generate
      if (LOAD_SLOTS == 0) begin : g_no_slot
         assign busy = !ready;
      end else begin : g_slot
         logic ld_q;
         always_ff @(posedge clk) begin
            if (rst)
               ld_q <= 1'b0;
            else if (load_en)
               ld_q <= load_is_ld;
         end
         // counts above the threshold belong to the unchecked slot window
         assign busy = !ready && !(ld_q && (cnt > CW'(SLOT_THR)));
      end
   endgenerate

   // R12: a pending counter drops by exactly one per clock
   p_count_down_r12: assert property (@(posedge clk) disable iff (rst)
      (!load_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R12: an idle zero counter stays at zero
   p_zero_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (!load_en && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/iil_hazard.sv
module iil_hazard #(
   parameter int NREGS = 32,
   parameter int IW    = 5
) (
   input  logic [NREGS-1:0] busy,
   input  logic [IW-1:0]    src_a,
   input  logic             use_a,
   input  logic [IW-1:0]    src_b,
   input  logic             use_b,
   input  logic [IW-1:0]    dst,
   input  logic             we,
   output logic             hazard
);
   logic raw_a, raw_b, waw;

   always_comb begin
      raw_a  = use_a && busy[src_a];
      raw_b  = use_b && busy[src_b];
      waw    = we && busy[dst];
      hazard = raw_a || raw_b || waw;
   end
endmodule

// File: rtl/iss_interlock.sv
module iss_interlock
   import iil_pkg::*;
#(
   parameter int NREGS      = 32,
   parameter int IW         = 5,
   parameter int LAT_ALU    = 1,
   parameter int LAT_LOAD   = 2,
   parameter int LOAD_SLOTS = 1,
   parameter int LAT_MUL    = 6,
   parameter int LAT_DIV    = 16,
   parameter int LAT_FSHORT = 2,
   parameter int LAT_FLONG  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             iss_valid,
   input  logic [2:0]       iss_class,
   input  logic [IW-1:0]    src_a,
   input  logic             src_a_use,
   input  logic [IW-1:0]    src_b,
   input  logic             src_b_use,
   input  logic [IW-1:0]    dst,
   input  logic             dst_we,
   output logic             stall,
   output logic [NREGS-1:0] reg_ready
);
   localparam int MAXL     = max_lat(LAT_ALU, LAT_LOAD, LAT_MUL, LAT_DIV, LAT_FSHORT, LAT_FLONG);
   localparam int CW       = $clog2(MAXL + 1);
   localparam int THR_RAW  = LAT_LOAD - 1 - LOAD_SLOTS;
   localparam int SLOT_THR = (THR_RAW > 0) ? THR_RAW : 0;

   generate
      if (NREGS != (1 << IW)) begin : g_bad_regs
         $error("NREGS must equal 2**IW");
      end
      if (LAT_ALU < 1 || LAT_LOAD < 1 || LAT_MUL < 1 || LAT_DIV < 1 ||
          LAT_FSHORT < 1 || LAT_FLONG < 1) begin : g_bad_lat
         $error("every latency must be at least one cycle");
      end
      if (LOAD_SLOTS < 0) begin : g_bad_slots
         $error("LOAD_SLOTS must not be negative");
      end
   endgenerate

   logic [CW-1:0]    lat_val;
   logic             lat_is_ld;
   logic             hazard;
   logic             accept;
   logic [NREGS-1:0] busy;

   iil_latency #(
      .LAT_ALU(LAT_ALU), .LAT_LOAD(LAT_LOAD), .LAT_MUL(LAT_MUL),
      .LAT_DIV(LAT_DIV), .LAT_FSHORT(LAT_FSHORT), .LAT_FLONG(LAT_FLONG),
      .CW(CW)
   ) u_lat (
      .cls(iss_class), .load_val(lat_val), .is_load(lat_is_ld)
   );

   iil_hazard #(.NREGS(NREGS), .IW(IW)) u_haz (
      .busy(busy), .src_a(src_a), .use_a(src_a_use), .src_b(src_b),
      .use_b(src_b_use), .dst(dst), .we(dst_we), .hazard(hazard)
   );

   assign stall  = iss_valid && hazard;
   assign accept = iss_valid && !hazard;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         if (i == 0) begin : g_zero
            assign busy[i]      = 1'b0;
            assign reg_ready[i] = 1'b1;
         end else begin : g_track
            logic hit;
            assign hit = accept && dst_we && (dst == IW'(i));
            iil_reg_slot #(
               .CW(CW), .LOAD_SLOTS(LOAD_SLOTS), .SLOT_THR(SLOT_THR)
            ) u_slot (
               .clk(clk), .rst(rst), .load_en(hit), .load_val(lat_val),
               .load_is_ld(lat_is_ld), .busy(busy[i]), .ready(reg_ready[i])
            );
         end
      end
   endgenerate

   // R1: leaving reset, nothing is pending
   p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (&reg_ready));

   // R11: no stall without a presented instruction
   p_stall_valid_r11: assert property (@(posedge clk) disable iff (rst)
      stall |-> iss_valid);

   // R2: the slot right after a load never waits on that load
   p_slot_free_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(accept && iss_class == 3'd1 && dst_we && dst != '0) &&
       iss_valid && src_a_use && src_a == $past(dst) && !src_b_use && !dst_we)
      |-> !stall);

   // R4: a multiply's destination is pending right after issue
   p_mul_pending_r4: assert property (@(posedge clk) disable iff (rst)
      (LAT_MUL > 1 && accept && iss_class == 3'd2 && dst_we && dst != '0)
      |=> !reg_ready[$past(dst)]);

   // R9: a held instruction leaves its ready destination untouched
   p_stall_freezes_r9: assert property (@(posedge clk) disable iff (rst)
      (stall && dst_we && dst != '0 && reg_ready[dst]) |=> reg_ready[$past(dst)]);

   // R8: register 0 as the only operand never blocks issue
   p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && dst_we && dst == '0 && !src_a_use && !src_b_use) |-> !stall);
endmodule

// File: tb/iss_interlock_tb.sv
module iss_interlock_tb;
   localparam int NR  = 32;
   localparam int LLD = 3;
   localparam int SLT = 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          iss_valid = 1'b0;
   logic [2:0]    iss_class = '0;
   logic [4:0]    src_a = '0, src_b = '0, dst = '0;
   logic          src_a_use = 1'b0, src_b_use = 1'b0, dst_we = 1'b0;
   logic          stall;
   logic [NR-1:0] reg_ready;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   int cnt_m [NR];
   bit ld_m  [NR];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   iss_interlock #(.LAT_LOAD(LLD), .LOAD_SLOTS(SLT)) u_dut (
      .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
      .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
      .dst(dst), .dst_we(dst_we), .stall(stall), .reg_ready(reg_ready)
   );

   function automatic int lat_of(input logic [2:0] c);
      case (c)
         3'd1: return LLD;
         3'd2: return 6;
         3'd3: return 16;
         3'd4: return 2;
         3'd5: return 3;
         default: return 1;
      endcase
   endfunction

   function automatic bit busy_m(input logic [4:0] r);
      if (r == 0 || cnt_m[r] == 0) return 1'b0;
      if (ld_m[r] && cnt_m[r] > (LLD - 1 - SLT)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic step(input string tag, input bit v, input logic [2:0] c,
                       input logic [4:0] a, input bit ua, input logic [4:0] b,
                       input bit ub, input logic [4:0] d, input bit we);
      bit            es;
      logic [NR-1:0] er;
      @(negedge clk);
      iss_valid = v; iss_class = c; src_a = a; src_a_use = ua;
      src_b = b; src_b_use = ub; dst = d; dst_we = we;
      #1;
      es = v && ((ua && busy_m(a)) || (ub && busy_m(b)) || (we && busy_m(d)));
      for (int i = 0; i < NR; i++) er[i] = (cnt_m[i] == 0);
      tests++;
      if (stall !== es) begin
         fails++;
         $display("FAIL %s stall: actual %0b expected %0b (cycle %0d)", tag, stall, es, cyc);
      end
      tests++;
      if (reg_ready !== er) begin
         fails++;
         $display("FAIL %s reg_ready: actual %h expected %h (cycle %0d)", tag, reg_ready, er, cyc);
      end
      @(posedge clk);
      for (int i = 0; i < NR; i++) if (cnt_m[i] > 0) cnt_m[i]--;
      if (v && !es && we && d != 0) begin
         cnt_m[d] = lat_of(c) - 1;
         ld_m[d]  = (c == 3'd1);
      end
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, 3'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin cnt_m[i] = 0; ld_m[i] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      idle("R1");
      // R2 / R3: load r5, slot reads it, next cycles interlock
      step("R2", 1, 3'd1, 5'd1, 1, 5'd0, 0, 5'd5, 1);
      step("R2", 1, 3'd0, 5'd5, 1, 5'd0, 0, 5'd20, 1);
      for (int k = 0; k < 3; k++) step("R3", 1, 3'd0, 5'd5, 1, 5'd0, 0, 5'd21, 1);
      // R2: slot instruction writes the load's destination
      step("R2", 1, 3'd1, 5'd1, 1, 5'd0, 0, 5'd6, 1);
      step("R2", 1, 3'd0, 5'd2, 1, 5'd0, 0, 5'd6, 1);
      idle("R12");
      // R4: multiply consumer
      step("R4", 1, 3'd2, 5'd1, 1, 5'd2, 1, 5'd7, 1);
      for (int k = 0; k < 7; k++) step("R4", 1, 3'd0, 5'd3, 1, 5'd7, 1, 5'd22, 1);
      // R5: divide consumer
      step("R5", 1, 3'd3, 5'd1, 1, 5'd2, 1, 5'd8, 1);
      for (int k = 0; k < 17; k++) step("R5", 1, 3'd0, 5'd8, 1, 5'd0, 0, 5'd23, 1);
      // R6: pipelined FP ops, then consumers
      step("R6", 1, 3'd4, 5'd1, 1, 5'd2, 1, 5'd9, 1);
      step("R6", 1, 3'd5, 5'd1, 1, 5'd2, 1, 5'd10, 1);
      step("R6", 1, 3'd4, 5'd3, 1, 5'd4, 1, 5'd11, 1);
      for (int k = 0; k < 4; k++) step("R6", 1, 3'd0, 5'd9, 1, 5'd10, 1, 5'd24, 1);
      step("R6", 1, 3'd0, 5'd11, 1, 5'd0, 0, 5'd25, 1);
      // R7: write-after-write on a pending multiply
      step("R7", 1, 3'd2, 5'd1, 1, 5'd0, 0, 5'd12, 1);
      for (int k = 0; k < 7; k++) step("R7", 1, 3'd0, 5'd0, 0, 5'd0, 0, 5'd12, 1);
      // R8: register 0 never pending
      step("R8", 1, 3'd3, 5'd1, 1, 5'd0, 0, 5'd0, 1);
      step("R8", 1, 3'd0, 5'd0, 1, 5'd0, 1, 5'd0, 1);
      // R9: stalled instruction keeps its destination ready
      step("R9", 1, 3'd2, 5'd1, 1, 5'd0, 0, 5'd13, 1);
      for (int k = 0; k < 6; k++) step("R9", 1, 3'd3, 5'd13, 1, 5'd0, 0, 5'd14, 1);
      for (int k = 0; k < 3; k++) idle("R9");
      // R10: masked source ignored
      step("R10", 1, 3'd3, 5'd1, 1, 5'd0, 0, 5'd15, 1);
      step("R10", 1, 3'd0, 5'd15, 0, 5'd15, 0, 5'd26, 1);
      // R11: invalid slot neither stalls nor loads
      step("R11", 1, 3'd3, 5'd1, 1, 5'd0, 0, 5'd16, 1);
      step("R11", 0, 3'd2, 5'd16, 1, 5'd16, 1, 5'd17, 1);
      for (int k = 0; k < 20; k++) idle("R11");
      // R12: class codes 6 and 7 behave as simple ops
      step("R12", 1, 3'd6, 5'd1, 1, 5'd0, 0, 5'd18, 1);
      step("R12", 1, 3'd7, 5'd18, 1, 5'd0, 0, 5'd19, 1);
      // mixed traffic on a small register window
      for (int k = 0; k < 600; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step("R3", lfsr[0] | lfsr[1], 3'(lfsr[4:2] % 3'd6), {2'b0, lfsr[7:5]}, lfsr[8],
              {2'b0, lfsr[11:9]}, lfsr[12], {2'b0, lfsr[15:13]}, lfsr[3] | lfsr[6]);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule